// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block forms the 12-bit data memory address used by a 4-bit microcontroller core. A 4-bit mode code picks how the address is built: from an 8-bit direct operand, from the H/L, D/E or D/L register pairs, or from the stack pointer. The upper four address bits give the memory bank. The bank comes from a bank-enable flag and a 4-bit bank register. In direct modes with the flag clear, it comes from the top bit of the operand instead. Some modes always use bank 0.

The address side is purely combinational. In the two stepping modes the block also computes the new L value (L plus one or L minus one, modulo 16) for the sequencer to write back. That write-back is registered by default and becomes combinational when the parameter `REG_LWB` is 0. Pair (8-bit) accesses are marked. An odd pair address is flagged and forced even. Mode codes with no meaning are flagged.

Top module: `dmag_addr_gen`

## Requirements
- R1: Mode 0 (4-bit direct) with `bank_en`=0 gives `addr` = {bank, `dir_op`}, where bank is 0 for `dir_op` 00h..7Fh and 15 for 80h..FFh; `pair`=0.
- R2: In modes 0 and 1 (direct) with `bank_en`=1, `addr[11:8]` equals `bank_sel` whatever the top bit of the operand.
- R3: Modes 2 (HL indirect), 3 (HL then increment L), 4 (HL then decrement L) and 7 (8-bit HL indirect) give `addr` = {bank, H, L}, with bank = `bank_sel` when `bank_en`=1 and 0 otherwise.
- R4: In mode 3 the stepped L is L+1, and in mode 4 it is L-1, both modulo 16. The address always uses the L value from before the step. `l_we` is 1 only for modes 3 and 4.
- R5: `l_wrap` is 1 when a step wraps L: an increment from Fh or a decrement from 0h. It is 0 on every other step.
- R6: Mode 5 gives `addr` = {0h, D, E} and mode 6 gives {0h, D, L}, whatever the values of `bank_en` and `bank_sel`.
- R7: Mode 8 (stack) gives `addr` = {0h, `sp`} whatever the values of `bank_en` and `bank_sel`.
- R8: Modes 1 and 7 set `pair`=1 and force `addr[0]` to 0. `align_err` is 1 exactly when the low address bit before forcing was 1. `align_err` is 0 in all other modes.
- R9: Mode codes 9..15 give `addr`=000h, `bad_mode`=1, `pair`=0 and no L write. `bad_mode` is 0 for codes 0..8.
- R10: With `REG_LWB`=1, the values of `l_we`, `l_new` and `l_wrap` for the mode present before a rising clock edge appear after that edge. Reset (`rst_n` low) clears all three to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the L write-back register |
| rst_n | input | 1 | Active-low reset |
| mode | input | 4 | Addressing mode code (0..8 valid) |
| dir_op | input | 8 | Direct operand |
| reg_h | input | 4 | H register |
| reg_l | input | 4 | L register |
| reg_d | input | 4 | D register |
| reg_e | input | 4 | E register |
| bank_en | input | 1 | Bank enable flag |
| bank_sel | input | 4 | Bank select register |
| sp | input | 8 | Stack pointer |
| addr | output | 12 | Data memory address |
| pair | output | 1 | 8-bit pair access |
| align_err | output | 1 | Odd address in a pair mode |
| bad_mode | output | 1 | Unused mode code |
| l_we | output | 1 | L write-back enable |
| l_new | output | 4 | New L value |
| l_wrap | output | 1 | L step wrapped |

## Verification
Direct operands are tried on both sides of 80h with the bank flag clear and set. This separates operand-driven banking from register-driven banking. HL, DE, DL and stack modes are driven with a nonzero bank register and the flag set, to show which modes ignore the bank. Stepping uses mid-range L values and the Fh/0h edges to tell normal steps from wrapping ones. Pair modes get odd and even low addresses, and every unused code is swept for the zero address and the flag.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int ADDR_W = NIB_W + BYTE_W;

    typedef enum logic [NIB_W-1:0] {
        M_DIR4   = 4'd0,
        M_DIR8   = 4'd1,
        M_HL     = 4'd2,
        M_HL_INC = 4'd3,
        M_HL_DEC = 4'd4,
        M_DE     = 4'd5,
        M_DL     = 4'd6,
        M_HL8    = 4'd7,
        M_STK    = 4'd8
    } mode_e;

    typedef struct packed {
        logic             we;
        logic             wrap;
        logic [NIB_W-1:0] val;
    } lwb_t;
endpackage

// File: rtl/dmag_bank_pick.sv
module dmag_bank_pick #(
    parameter int W = 4
) (
    input  logic         bank_en,
    input  logic [W-1:0] bank_sel,
    input  logic         op_msb,
    output logic [W-1:0] dir_bank,
    output logic [W-1:0] ind_bank
);
    // direct: register bank when enabled, else bank 0 or the top bank
    always_comb begin
        dir_bank = bank_en ? bank_sel : {W{op_msb}};
        ind_bank = bank_en ? bank_sel : '0;
    end
endmodule

// File: rtl/dmag_l_step.sv
module dmag_l_step #(
    parameter int W = 4
) (
    input  logic [W-1:0] l_in,
    input  logic         down,
    output logic [W-1:0] l_out,
    output logic         wrap
);
    always_comb begin
        if (down) begin
            l_out = l_in - 1'b1;
            wrap  = (l_in == '0);
        end else begin
            l_out = l_in + 1'b1;
            wrap  = (l_in == '1);
        end
    end
endmodule

// File: rtl/dmag_addr_gen.sv
module dmag_addr_gen
    import dmag_pkg::*;
#(
    parameter bit REG_LWB = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  mode,
    input  logic [BYTE_W-1:0] dir_op,
    input  logic [NIB_W-1:0]  reg_h,
    input  logic [NIB_W-1:0]  reg_l,
    input  logic [NIB_W-1:0]  reg_d,
    input  logic [NIB_W-1:0]  reg_e,
    input  logic              bank_en,
    input  logic [NIB_W-1:0]  bank_sel,
    input  logic [BYTE_W-1:0] sp,
    output logic [ADDR_W-1:0] addr,
    output logic              pair,
    output logic              align_err,
    output logic              bad_mode,
    output logic              l_we,
    output logic [NIB_W-1:0]  l_new,
    output logic              l_wrap
);
    logic [NIB_W-1:0]  dir_bank, ind_bank, bank, l_step;
    logic [BYTE_W-1:0] low;
    logic              step_en, step_down, step_wrap;
    lwb_t              lwb_d, lwb_q;

    dmag_bank_pick #(.W(NIB_W)) u_bank (
        .bank_en  (bank_en),
        .bank_sel (bank_sel),
        .op_msb   (dir_op[BYTE_W-1]),
        .dir_bank (dir_bank),
        .ind_bank (ind_bank)
    );

    dmag_l_step #(.W(NIB_W)) u_step (
        .l_in  (reg_l),
        .down  (step_down),
        .l_out (l_step),
        .wrap  (step_wrap)
    );

    always_comb begin
        bank      = '0;
        low       = '0;
        pair      = 1'b0;
        bad_mode  = 1'b0;
        step_en   = 1'b0;
        step_down = 1'b0;
        case (mode)
            M_DIR4: begin
                bank = dir_bank;
                low  = dir_op;
            end
            M_DIR8: begin
                bank = dir_bank;
                low  = dir_op;
                pair = 1'b1;
            end
            M_HL: begin
                bank = ind_bank;
                low  = {reg_h, reg_l};
            end
            M_HL8: begin
                bank = ind_bank;
                low  = {reg_h, reg_l};
                pair = 1'b1;
            end
            M_HL_INC: begin
                bank    = ind_bank;
                low     = {reg_h, reg_l};
                step_en = 1'b1;
            end
            M_HL_DEC: begin
                bank      = ind_bank;
                low       = {reg_h, reg_l};
                step_en   = 1'b1;
                step_down = 1'b1;
            end
            M_DE:    low = {reg_d, reg_e};
            M_DL:    low = {reg_d, reg_l};
            M_STK:   low = sp;
            default: bad_mode = 1'b1;
        endcase
        align_err = pair & low[0];
        addr      = {bank, low[BYTE_W-1:1], low[0] & ~pair};

        lwb_d.we   = step_en;
        lwb_d.wrap = step_en & step_wrap;
        lwb_d.val  = step_en ? l_step : '0;
    end

    generate
        if (REG_LWB) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lwb_q <= '0;
                else        lwb_q <= lwb_d;
            end
        end else begin : g_comb
            always_comb lwb_q = lwb_d;
        end
    endgenerate

    always_comb begin
        l_we   = lwb_q.we;
        l_new  = lwb_q.val;
        l_wrap = lwb_q.wrap;
    end
endmodule

// File: rtl/dmag_checker.sv
module dmag_checker
    import dmag_pkg::*;
#(
    parameter bit REG_LWB = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NIB_W-1:0]  mode,
    input logic              bank_en,
    input logic [ADDR_W-1:0] addr,
    input logic              pair,
    input logic              align_err,
    input logic              bad_mode,
    input logic              l_we,
    input logic              l_wrap
);
    a_r6_fixed_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_DE || mode == M_DL) |-> addr[ADDR_W-1:BYTE_W] == '0);

    a_r7_stack_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_STK) |-> addr[ADDR_W-1:BYTE_W] == '0);

    a_r3_hl_bank_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_en && (mode == M_HL || mode == M_HL8 || mode == M_HL_INC || mode == M_HL_DEC))
        |-> addr[ADDR_W-1:BYTE_W] == '0);

    a_r8_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
        pair |-> !addr[0]);

    a_r8_align_only_pair: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> pair);

    a_r9_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode |-> (addr == '0 && !pair && !align_err));

    a_r5_wrap_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        l_wrap |-> l_we);

    generate
        if (REG_LWB) begin : g_reg_chk
            a_r10_we_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
                l_we |-> ($past(mode) == M_HL_INC || $past(mode) == M_HL_DEC));
        end
    endgenerate
endmodule

bind dmag_addr_gen dmag_checker #(.REG_LWB(REG_LWB)) u_chk (.*);

// File: tb/tb_dmag_addr_gen.sv
module tb_dmag_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  dir_op = '0;
    logic [3:0]  reg_h = '0, reg_l = '0, reg_d = '0, reg_e = '0;
    logic        bank_en = 1'b0;
    logic [3:0]  bank_sel = '0;
    logic [7:0]  sp = '0;
    logic [11:0] addr;
    logic        pair, align_err, bad_mode, l_we, l_wrap;
    logic [3:0]  l_new;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmag_addr_gen #(.REG_LWB(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dir_op(dir_op),
        .reg_h(reg_h), .reg_l(reg_l), .reg_d(reg_d), .reg_e(reg_e),
        .bank_en(bank_en), .bank_sel(bank_sel), .sp(sp),
        .addr(addr), .pair(pair), .align_err(align_err), .bad_mode(bad_mode),
        .l_we(l_we), .l_new(l_new), .l_wrap(l_wrap)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at the falling edge, let combinational outputs settle
    task automatic drive(input logic [3:0] m, input logic [7:0] op, input logic en,
                         input logic [3:0] bs);
        @(negedge clk);
        mode = m; dir_op = op; bank_en = en; bank_sel = bs;
        #1;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        mode = 4'd3; reg_l = 4'h7;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset l_we", l_we, 0);
        check("R10 reset l_new", l_new, 0);
        check("R10 reset l_wrap", l_wrap, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_r1_direct_flag_clear();
        drive(4'd0, 8'h7F, 1'b0, 4'h6);
        check("R1 op 7F", addr, 12'h07F);
        check("R1 pair", pair, 0);
        drive(4'd0, 8'h80, 1'b0, 4'h6);
        check("R1 op 80", addr, 12'hF80);
        drive(4'd0, 8'h00, 1'b0, 4'h6);
        check("R1 op 00", addr, 12'h000);
        drive(4'd0, 8'hFF, 1'b0, 4'h6);
        check("R1 op FF", addr, 12'hFFF);
    endtask

    task automatic t_r2_direct_flag_set();
        drive(4'd0, 8'h85, 1'b1, 4'h3);
        check("R2 op 85 bank 3", addr, 12'h385);
        drive(4'd0, 8'h12, 1'b1, 4'hA);
        check("R2 op 12 bank A", addr, 12'hA12);
        drive(4'd1, 8'hC4, 1'b1, 4'h5);
        check("R2 pair bank 5", addr, 12'h5C4);
    endtask

    task automatic t_r3_hl();
        reg_h = 4'hB; reg_l = 4'h6;
        drive(4'd2, 8'h00, 1'b1, 4'h9);
        check("R3 HL bank on", addr, 12'h9B6);
        drive(4'd2, 8'h00, 1'b0, 4'h9);
        check("R3 HL bank off", addr, 12'h0B6);
        check("R3 HL no pair", pair, 0);
    endtask

    task automatic t_r4_r5_step();
        reg_h = 4'h2; reg_l = 4'h5;
        drive(4'd3, 8'h00, 1'b1, 4'h4);
        check("R4 inc addr uses old L", addr, 12'h425);
        after_edge();
        check("R4 inc l_we", l_we, 1);
        check("R4 inc l_new", l_new, 4'h6);
        check("R5 inc no wrap", l_wrap, 0);
        drive(4'd4, 8'h00, 1'b0, 4'h4);
        check("R4 dec addr", addr, 12'h025);
        after_edge();
        check("R4 dec l_new", l_new, 4'h4);
        check("R5 dec no wrap", l_wrap, 0);
        reg_l = 4'hF;
        drive(4'd3, 8'h00, 1'b0, 4'h0);
        after_edge();
        check("R5 inc F wraps l_new", l_new, 4'h0);
        check("R5 inc F wrap flag", l_wrap, 1);
        reg_l = 4'h0;
        drive(4'd4, 8'h00, 1'b0, 4'h0);
        after_edge();
        check("R5 dec 0 wraps l_new", l_new, 4'hF);
        check("R5 dec 0 wrap flag", l_wrap, 1);
        drive(4'd2, 8'h00, 1'b0, 4'h0);
        after_edge();
        check("R4 no step in mode 2", l_we, 0);
    endtask

    task automatic t_r10_timing();
        reg_l = 4'h9;
        drive(4'd3, 8'h00, 1'b0, 4'h0);
        check("R10 not yet visible", l_we, 0);
        after_edge();
        check("R10 visible after edge", l_new, 4'hA);
    endtask

    task automatic t_r6_r7_fixed();
        reg_d = 4'hC; reg_e = 4'h3; reg_l = 4'h8; sp = 8'hE7;
        drive(4'd5, 8'h00, 1'b1, 4'hD);
        check("R6 DE bank 0", addr, 12'h0C3);
        drive(4'd6, 8'h00, 1'b1, 4'hD);
        check("R6 DL bank 0", addr, 12'h0C8);
        drive(4'd8, 8'h00, 1'b1, 4'hD);
        check("R7 stack bank 0", addr, 12'h0E7);
        check("R7 stack no pair", pair, 0);
    endtask

    task automatic t_r8_pair();
        drive(4'd1, 8'h3B, 1'b0, 4'h0);
        check("R8 direct odd addr", addr, 12'h03A);
        check("R8 direct odd err", align_err, 1);
        check("R8 direct pair", pair, 1);
        drive(4'd1, 8'h9C, 1'b0, 4'h0);
        check("R8 direct even addr", addr, 12'hF9C);
        check("R8 direct even no err", align_err, 0);
        reg_h = 4'h4; reg_l = 4'h7;
        drive(4'd7, 8'h00, 1'b1, 4'h2);
        check("R8 HL8 odd addr", addr, 12'h246);
        check("R8 HL8 odd err", align_err, 1);
        drive(4'd2, 8'h00, 1'b1, 4'h2);
        check("R8 odd non-pair no err", align_err, 0);
        check("R8 odd non-pair keeps bit0", addr, 12'h247);
    endtask

    task automatic t_r9_invalid();
        for (int c = 9; c < 16; c++) begin
            drive(4'(c), 8'hFF, 1'b1, 4'hF);
            check("R9 addr zero", addr, 12'h000);
            check("R9 bad_mode", bad_mode, 1);
            check("R9 no pair", pair, 0);
            after_edge();
            check("R9 no L write", l_we, 0);
        end
        drive(4'd8, 8'h00, 1'b0, 4'h0);
        check("R9 valid code clear", bad_mode, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_r1_direct_flag_clear();
                t_r2_direct_flag_set();
                t_r3_hl();
                t_r4_r5_step();
                t_r10_timing();
                t_r6_r7_fixed();
                t_r8_pair();
                t_r9_invalid();
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule